// File: doc/BRIEF.md
# Tone Transceiver Bus-Register Controller

This block is the register file and transmit burst sequencer of a telephone-tone transceiver. It sits on a small processor bus with an active-low chip select, a register-select line, a read/write line and a data strobe. The data path is four bits wide, and the block drives an active-low interrupt line. Analog synthesis and detection stay outside the block. It hands a 4-bit digit code and a tone-enable to an external generator. It takes a 4-bit code and a one-cycle strobe from an external detector.

Software writes a digit to the transmit register. The sequencer then enables the tone for one burst and holds it off for an equal pause. It times both from a millisecond built out of `TICKS_PER_MS` pulses of `msTick`. Only after the pause does it report that it is ready for the next digit. An extended mode doubles both phases. Two control registers share one bus address. A steering bit written to the first one sends the next control write to the second.

Top module: `tone_bus_ctrl`

## Requirements
- R1: After reset the status register reads 0000, the receive register reads 0000, `irqN` is 1 and `toneEn` is 0.
- R2: An access happens only in a cycle where `csN` is 0 and `strobe` is 1. With `regSel`=1, a write (`rdWr`=0) goes to control and a read (`rdWr`=1) returns status. With `regSel`=0, a write goes to the transmit register and a read returns the receive register. A write with `csN`=1 has no effect, and a transmit write does not change what a receive read returns.
- R3: Control register A holds bit0 = tone output enable, bit1 = alternate tone mode (driven on `toneMode`), bit2 = interrupt enable. A control write with bit3=1 steers the next control write to register B, and the write after that goes to A again. Register B bit0 selects extended burst. The sequence status read, control writes 0, 0, 8, 0, status read leaves both registers cleared.
- R4: A transmit write loads `toneCode` with the written digit in binary. `toneEn` is 1 only while the burst phase runs and A bit0 is 1.
- R5: In normal mode the burst lasts `BURST_MS` ms. Status bit1 becomes 1 exactly 2×`BURST_MS` ms after the transmit write, and is 0 before that.
- R6: With B bit0=1 the burst and pause each last 2×`BURST_MS` ms, so status bit1 is set after 4×`BURST_MS` ms.
- R7: A cycle with `detValid`=1 stores `detCode` and sets status bit2. A receive read returns the stored code and clears bit2.
- R8: The status layout is bit0 = interrupt flag, bit1 = transmitter ready, bit2 = receive full, bit3 = 0. The flag is set whenever bit1 or bit2 is set, and a status read clears the flag and bit1.
- R9: `irqN` is 0 exactly when A bit2 is 1 and status bit1 or bit2 is 1.
- R10: When a set event and a clearing read fall in the same cycle, the set wins. A detector strobe during a receive read leaves bit2 set and stores the new code. The end of a pause during a status read leaves bit1 and the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select, active low |
| regSel | input | 1 | 1 = control/status, 0 = transmit/receive data |
| rdWr | input | 1 | 1 = read, 0 = write |
| strobe | input | 1 | Data strobe, qualifies an access |
| dataIn | input | 4 | Write data |
| dataOut | output | 4 | Read data (status or receive register) |
| irqN | output | 1 | Interrupt request, active low |
| msTick | input | 1 | Time-base pulse, `TICKS_PER_MS` per millisecond |
| toneEn | output | 1 | Tone enable to the generator |
| toneMode | output | 1 | Alternate tone mode to the generator |
| toneCode | output | 4 | Digit code to the generator |
| detCode | input | 4 | Digit code from the detector |
| detValid | input | 1 | One-cycle strobe: `detCode` is valid |

## Verification
Two pairs of events can land on the same clock edge. A detector strobe can arrive during a receive-register read, and the last time-base pulse of a pause can arrive during a status read. The bench drives each pair in one bus cycle. It expects the read to return the value from before the edge, and a later status read to show the set flags still standing.

// File: rtl/tone_pkg.sv
package tone_pkg;
  typedef struct packed {
    logic wrCtrl;
    logic wrTx;
    logic rdStat;
    logic rdRx;
    logic burstDone;
  } toneStrb_t;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_BURST, SEQ_PAUSE} seqState_t;
endpackage

// File: rtl/tone_bus_ctrl_ctl.sv
module tone_bus_ctrl_ctl
  import tone_pkg::*;
#(
  parameter int TICKS_PER_MS = 8,
  parameter int BURST_MS     = 50
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      csN,
  input  logic      regSel,
  input  logic      rdWr,
  input  logic      strobe,
  input  logic      msTick,
  input  logic      extBurst,
  input  logic      toneOutEn,
  output toneStrb_t strb,
  output logic      toneEn,
  output logic      inPause
);
  localparam int TICK_W = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;
  localparam int MS_W   = $clog2(2 * BURST_MS + 1);
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(TICKS_PER_MS - 1);
  localparam logic [MS_W-1:0]   PH_NORM   = MS_W'(BURST_MS - 1);
  localparam logic [MS_W-1:0]   PH_EXT    = MS_W'(2 * BURST_MS - 1);

  seqState_t         state;
  logic [TICK_W-1:0] tickCnt;
  logic [MS_W-1:0]   msCnt;
  logic              access, msDone, phaseEnd;
  logic [MS_W-1:0]   phaseLast;

  // bus decode into strobes
  always_comb begin
    access         = !csN && strobe;
    strb.wrCtrl    = access && regSel && !rdWr;
    strb.rdStat    = access && regSel && rdWr;
    strb.wrTx      = access && !regSel && !rdWr;
    strb.rdRx      = access && !regSel && rdWr;
    phaseLast      = extBurst ? PH_EXT : PH_NORM;
    msDone         = msTick && (tickCnt == TICK_LAST);
    phaseEnd       = msDone && (msCnt >= phaseLast);
    // a new transmit write restarts the sequence and masks completion
    strb.burstDone = (state == SEQ_PAUSE) && phaseEnd && !strb.wrTx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= SEQ_IDLE;
      tickCnt <= '0;
      msCnt   <= '0;
    end else if (strb.wrTx) begin
      state   <= SEQ_BURST;
      tickCnt <= '0;
      msCnt   <= '0;
    end else if (state != SEQ_IDLE && msTick) begin
      if (msDone) begin
        tickCnt <= '0;
        if (phaseEnd) begin
          msCnt <= '0;
          state <= (state == SEQ_BURST) ? SEQ_PAUSE : SEQ_IDLE;
        end else begin
          msCnt <= msCnt + 1'b1;
        end
      end else begin
        tickCnt <= tickCnt + 1'b1;
      end
    end
  end

  assign toneEn  = (state == SEQ_BURST) && toneOutEn;
  assign inPause = (state == SEQ_PAUSE);
endmodule

// File: rtl/tone_bus_ctrl_dp.sv
module tone_bus_ctrl_dp
  import tone_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  toneStrb_t  strb,
  input  logic       regSel,
  input  logic [3:0] dataIn,
  input  logic [3:0] detCode,
  input  logic       detValid,
  output logic [3:0] dataOut,
  output logic       irqN,
  output logic [3:0] toneCode,
  output logic       toneOutEn,
  output logic       toneMode,
  output logic       irqEnable,
  output logic       extBurst,
  output logic       pointB,
  output logic       txReady,
  output logic       rxFull
);
  logic [2:0] ctrlA;
  logic       ctrlB;
  logic [3:0] rxData;
  logic       irqFlag;
  logic [3:0] status;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlA    <= '0;
      ctrlB    <= 1'b0;
      pointB   <= 1'b0;
      toneCode <= '0;
      rxData   <= '0;
      rxFull   <= 1'b0;
      txReady  <= 1'b0;
      irqFlag  <= 1'b0;
    end else begin
      if (strb.wrCtrl) begin
        if (pointB) begin
          ctrlB  <= dataIn[0];
          pointB <= 1'b0;
        end else begin
          ctrlA  <= dataIn[2:0];
          pointB <= dataIn[3];
        end
      end
      if (strb.wrTx) toneCode <= dataIn;

      if (strb.burstDone)                 txReady <= 1'b1;
      else if (strb.wrTx || strb.rdStat)  txReady <= 1'b0;

      if (detValid) begin
        rxData <= detCode;
        rxFull <= 1'b1;
      end else if (strb.rdRx) begin
        rxFull <= 1'b0;
      end

      if (strb.burstDone || detValid) irqFlag <= 1'b1;
      else if (strb.rdStat)           irqFlag <= 1'b0;
    end
  end

  always_comb begin
    status  = {1'b0, rxFull, txReady, irqFlag};
    dataOut = regSel ? status : rxData;
  end

  assign toneOutEn = ctrlA[0];
  assign toneMode  = ctrlA[1];
  assign irqEnable = ctrlA[2];
  assign extBurst  = ctrlB;
  assign irqN      = !(irqEnable && (txReady || rxFull));
endmodule

// File: rtl/tone_bus_ctrl.sv
module tone_bus_ctrl
  import tone_pkg::*;
#(
  parameter int TICKS_PER_MS = 8,
  parameter int BURST_MS     = 50
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       regSel,
  input  logic       rdWr,
  input  logic       strobe,
  input  logic [3:0] dataIn,
  output logic [3:0] dataOut,
  output logic       irqN,
  input  logic       msTick,
  output logic       toneEn,
  output logic       toneMode,
  output logic [3:0] toneCode,
  input  logic [3:0] detCode,
  input  logic       detValid
);
  toneStrb_t strb;
  logic toneOutEn, irqEnable, extBurst, pointB, txReady, rxFull, inPause;

  tone_bus_ctrl_ctl #(.TICKS_PER_MS(TICKS_PER_MS), .BURST_MS(BURST_MS)) ctl_i (
    .clk(clk), .rstN(rstN), .csN(csN), .regSel(regSel), .rdWr(rdWr),
    .strobe(strobe), .msTick(msTick), .extBurst(extBurst),
    .toneOutEn(toneOutEn), .strb(strb), .toneEn(toneEn), .inPause(inPause)
  );

  tone_bus_ctrl_dp dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .regSel(regSel), .dataIn(dataIn),
    .detCode(detCode), .detValid(detValid), .dataOut(dataOut), .irqN(irqN),
    .toneCode(toneCode), .toneOutEn(toneOutEn), .toneMode(toneMode),
    .irqEnable(irqEnable), .extBurst(extBurst), .pointB(pointB),
    .txReady(txReady), .rxFull(rxFull)
  );
endmodule

// File: rtl/tone_bus_ctrl_chk.sv
module tone_bus_ctrl_chk (
  input logic       clk,
  input logic       rstN,
  input logic       toneEn,
  input logic       txReady,
  input logic       rxFull,
  input logic       detValid,
  input logic       rdStat,
  input logic       burstDone,
  input logic       wrTx,
  input logic       wrCtrl,
  input logic       pointB,
  input logic       irqEnable,
  input logic       irqN,
  input logic       inPause,
  input logic [3:0] toneCode,
  input logic [3:0] dataIn
);
  AST_READY_AFTER_PAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txReady) |-> $past(inPause)); // R5
  AST_TONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    toneEn |-> !txReady); // R4
  AST_TX_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    wrTx |=> (!txReady && toneCode == $past(dataIn))); // R4
  AST_RX_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    detValid |=> rxFull); // R7
  AST_STATUS_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (rdStat && !burstDone) |=> !txReady); // R8
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    !irqEnable |-> irqN); // R9
  AST_POINTER_RETURNS: assert property (@(posedge clk) disable iff (!rstN)
    (wrCtrl && pointB) |=> !pointB); // R3
endmodule

bind tone_bus_ctrl tone_bus_ctrl_chk chk_i (
  .clk(clk), .rstN(rstN), .toneEn(toneEn), .txReady(txReady), .rxFull(rxFull),
  .detValid(detValid), .rdStat(strb.rdStat), .burstDone(strb.burstDone),
  .wrTx(strb.wrTx), .wrCtrl(strb.wrCtrl), .pointB(pointB),
  .irqEnable(irqEnable), .irqN(irqN), .inPause(inPause),
  .toneCode(toneCode), .dataIn(dataIn)
);

// File: tb/tone_bus_ctrl_tb_top.sv
module tone_bus_ctrl_tb_top;
  localparam int CLK_P = 10;
  localparam int Q     = CLK_P / 4;
  localparam int TPM   = 2;
  localparam int BMS   = 3;
  localparam int PH    = TPM * BMS;   // ticks per normal phase

  logic clk = 0, rstN = 0;
  logic csN = 1, regSel = 0, rdWr = 1, strobe = 0, msTick = 0, detValid = 0;
  logic [3:0] dataIn = '0, detCode = '0;
  logic [3:0] dataOut, toneCode;
  logic irqN, toneEn, toneMode;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [3:0] expQ[$];
  string      tagQ[$];

  always #(CLK_P/2) clk = ~clk;

  tone_bus_ctrl #(.TICKS_PER_MS(TPM), .BURST_MS(BMS)) dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .regSel(regSel), .rdWr(rdWr),
    .strobe(strobe), .dataIn(dataIn), .dataOut(dataOut), .irqN(irqN),
    .msTick(msTick), .toneEn(toneEn), .toneMode(toneMode), .toneCode(toneCode),
    .detCode(detCode), .detValid(detValid)
  );

  task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compares read data against the scoreboard queue
  always @(negedge clk) begin
    if (rstN && !csN && strobe && rdWr) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL unexpected read: actual=%h expected=none", dataOut);
      end else begin
        logic [3:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (dataOut !== e) begin
          errors++;
          $display("FAIL %s read: actual=%h expected=%h", t, dataOut, e);
        end
      end
    end
  end

  task automatic busAcc(logic sel, logic rd, logic [3:0] d, logic [3:0] exp,
                        string tag, logic tk, logic dv, logic [3:0] dc);
    @(posedge clk); #(Q);
    csN = 0; strobe = 1; regSel = sel; rdWr = rd; dataIn = d;
    msTick = tk; detValid = dv; detCode = dc;
    if (rd) begin expQ.push_back(exp); tagQ.push_back(tag); end
    @(posedge clk); #(Q);
    csN = 1; strobe = 0; rdWr = 1; msTick = 0; detValid = 0;
  endtask

  task automatic wrReg(logic sel, logic [3:0] d);
    busAcc(sel, 1'b0, d, 4'h0, "", 1'b0, 1'b0, 4'h0);
  endtask

  task automatic rdReg(logic sel, logic [3:0] exp, string tag);
    busAcc(sel, 1'b1, 4'h0, exp, tag, 1'b0, 1'b0, 4'h0);
  endtask

  task automatic tickN(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #(Q); msTick = 1;
      @(posedge clk); #(Q); msTick = 0;
    end
  endtask

  task automatic detPulse(logic [3:0] c);
    @(posedge clk); #(Q); detValid = 1; detCode = c;
    @(posedge clk); #(Q); detValid = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #(Q); rstN = 1;
    @(posedge clk); #(Q);
    // R1 reset state
    chk("R1 irqN", {3'b0, irqN}, 4'h1);
    chk("R1 toneEn", {3'b0, toneEn}, 4'h0);
    rdReg(1, 4'h0, "R1 status");
    rdReg(0, 4'h0, "R1 rx");

    // R2 write with chip select high is ignored
    @(posedge clk); #(Q);
    csN = 1; strobe = 1; regSel = 1; rdWr = 0; dataIn = 4'b0101;
    @(posedge clk); #(Q); strobe = 0; rdWr = 1;
    wrReg(0, 4'h7);
    chk("R2 toneEn after ignored write", {3'b0, toneEn}, 4'h0);
    chk("R4 toneCode", toneCode, 4'h7);
    tickN(2*PH);
    chk("R2 irqN masked", {3'b0, irqN}, 4'h1);
    rdReg(1, 4'b0011, "R8 status ready");
    rdReg(1, 4'b0000, "R8 status cleared");

    // R5 normal burst
    wrReg(1, 4'b0101);
    wrReg(0, 4'h7);
    chk("R4 toneEn on", {3'b0, toneEn}, 4'h1);
    chk("R4 toneCode 7", toneCode, 4'h7);
    tickN(PH-1);
    chk("R5 tone still on", {3'b0, toneEn}, 4'h1);
    tickN(1);
    chk("R5 tone off at pause", {3'b0, toneEn}, 4'h0);
    tickN(PH-1);
    chk("R5 not ready yet", {3'b0, irqN}, 4'h1);
    tickN(1);
    chk("R5 ready irq", {3'b0, irqN}, 4'h0);
    rdReg(1, 4'b0011, "R8 status after burst");
    chk("R9 irq released", {3'b0, irqN}, 4'h1);

    // R6 extended burst
    wrReg(1, 4'b1101);
    wrReg(1, 4'b0001);
    wrReg(0, 4'h5);
    chk("R4 toneCode 5", toneCode, 4'h5);
    tickN(2*PH-1);
    chk("R6 tone still on", {3'b0, toneEn}, 4'h1);
    tickN(1);
    chk("R6 tone off", {3'b0, toneEn}, 4'h0);
    tickN(2*PH-1);
    chk("R6 not ready yet", {3'b0, irqN}, 4'h1);
    tickN(1);
    chk("R6 ready irq", {3'b0, irqN}, 4'h0);
    rdReg(1, 4'b0011, "R6 status");

    // R3 pointer returned to A, B kept
    wrReg(1, 4'b0100);
    chk("R3 toneMode", {3'b0, toneMode}, 4'h0);
    wrReg(0, 4'h2);
    chk("R3 write went to A", {3'b0, toneEn}, 4'h0);
    tickN(4*PH-1);
    chk("R3 B still extended", {3'b0, irqN}, 4'h1);
    tickN(1);
    chk("R3 ready extended", {3'b0, irqN}, 4'h0);
    rdReg(1, 4'b0011, "R3 status");

    // R3 software reset sequence
    rdReg(1, 4'b0000, "R3 reset seq read");
    wrReg(1, 4'h0); wrReg(1, 4'h0); wrReg(1, 4'h8); wrReg(1, 4'h0);
    rdReg(1, 4'b0000, "R3 reset seq read2");
    wrReg(0, 4'h1);
    chk("R3 tone cleared", {3'b0, toneEn}, 4'h0);
    tickN(2*PH);
    chk("R3 irq cleared", {3'b0, irqN}, 4'h1);
    rdReg(1, 4'b0011, "R3 normal timing after reset");

    // R7 receive path
    wrReg(1, 4'b0110);
    chk("R3 toneMode set", {3'b0, toneMode}, 4'h1);
    detPulse(4'h9);
    chk("R9 irq on rx", {3'b0, irqN}, 4'h0);
    rdReg(1, 4'b0101, "R7 status rx full");
    chk("R9 irq held by rx full", {3'b0, irqN}, 4'h0);
    rdReg(0, 4'h9, "R7 rx data");
    chk("R7 irq after rx read", {3'b0, irqN}, 4'h1);
    rdReg(1, 4'b0000, "R7 status after rx read");

    // R10 detector strobe during receive read
    detPulse(4'h3);
    busAcc(0, 1'b1, 4'h0, 4'h3, "R10 rx read old", 1'b0, 1'b1, 4'h6);
    rdReg(1, 4'b0101, "R10 rx full kept");
    rdReg(0, 4'h6, "R10 new code");
    rdReg(1, 4'b0000, "R10 status drained");

    // R10 pause end during status read
    wrReg(0, 4'h4);
    tickN(2*PH-1);
    busAcc(1, 1'b1, 4'h0, 4'b0000, "R10 status before done", 1'b1, 1'b0, 4'h0);
    chk("R10 irq after collision", {3'b0, irqN}, 4'h0);
    rdReg(1, 4'b0011, "R10 ready kept");

    // R2 transmit write does not alter receive read
    wrReg(0, 4'hA);
    rdReg(0, 4'h6, "R2 rx unaffected");

    @(negedge clk);
    if (expQ.size() != 0) begin
      checks++; errors++;
      $display("FAIL R2 pending reads: actual=%0d expected=0", expQ.size());
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule